// File: doc/BRIEF.md
# Sync-Locked Overlay Pixel Serializer

This block turns bytes of character pixel data from a slow controller into a serial stream of overlay pixels. The stream is phase-locked to the end of every horizontal sync pulse. A divider makes one pixel tick for every two oscillator cycles. An eight-slot load sequencer chooses which pixel tick parallel-loads the next byte. A shift register moves the bits out most significant first. The divider, the sequencer and the shift register are all held cleared while sync is active and start together on the first oscillator edge after sync ends. Each line's pixel grid therefore sits in a fixed place relative to the sync trailing edge, to within half a pixel.

The controller gets a one-cycle request pulse each time a byte is taken. It then has a full byte time (16 oscillator cycles by default) to present the next byte. The controller keeps the byte at zero until the character area begins. An enable input replaces the loaded byte with zero, so that whole character cells can be blanked. The single overlay output is high only for '1' pixels. Mixing this output into the analog video is done outside the block.

Top module: `hsync_pixel_serializer`

## Requirements
- R1: While reset is active and on release, `overlay` and `byte_req` are low.
- R2: On every clock edge that samples `hsync` high, the shift register is cleared and no byte is loaded. From the next cycle on, `overlay` and `byte_req` are low.
- R3: Call E0 the first edge that samples `hsync` low after it was high. The first byte of the line is loaded on edge E1, and its bit 7 appears on `overlay` right after E1.
- R4: Each pixel lasts exactly two clock cycles. Bits leave in the order bit 7 down to bit 0, and `overlay` is high exactly for '1' bits.
- R5: A new byte is loaded every 16 clock cycles, on edges E1+16j. The edge that loads a byte is the edge on which bit 0 of the previous byte stops being shown, so no gap appears between bytes.
- R6: `byte_req` goes high for exactly one cycle after each load edge and is low at all other times.
- R7: `pix_byte` is sampled only on load edges. Changing it between loads has no effect on the pixels being shown.
- R8: If `en` is low on a load edge, zero is loaded in place of `pix_byte`. `overlay` then stays low for that whole byte time, and `byte_req` still pulses.
- R9: Pixel timing after sync depends only on the sync trailing edge. It does not depend on the sync pulse width or on where a previous line was cut off by sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high, synchronous to clk |
| en | input | 1 | Load enable; when low, zero is loaded |
| pix_byte | input | 8 | Next byte of pixels, bit 7 shown first |
| byte_req | output | 1 | One-cycle pulse after each byte load |
| overlay | output | 1 | Serial overlay pixel, high for '1' pixels |

## Verification
The bench goes after the first-load edge after sync. If the divider were not restarted by sync, the first pixel would land one cycle early or late, depending on the phase the line was cut at. To catch this, lines follow sync pulses of odd and even widths, and one line is cut off mid-byte on an odd cycle. Between loads the bench drives the inverse of the real byte on `pix_byte`. A design that samples the input at any time other than the load edge would show inverted pixels. The bench also runs bytes with enable low and byte boundaries with alternating patterns, which catches a lost or doubled pixel at the reload, a bit order that starts from the wrong end, and a request that is missing or wider than one cycle.

// File: rtl/hsp_pkg.sv
// Package: shared sizing for the sync-locked overlay pixel serializer.
// Assumes one byte holds PIX_PER_BYTE pixels and one pixel lasts
// CLK_PER_PIX oscillator cycles.
package hsp_pkg;
    localparam int PIX_PER_BYTE_DEF = 8;
    localparam int CLK_PER_PIX_DEF  = 2;

    // Width of a counter that spans n states (at least one bit).
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/hsp_pixdiv.sv
// Module: pixel clock divider.
// Makes a one-cycle pixel tick once every CLK_PER_PIX clock cycles.
// While hsync is high the phase counter is held at zero. The first tick
// after sync therefore comes exactly CLK_PER_PIX-1 edges after the first
// edge that samples hsync low, whatever phase the counter had before.
// Assumes hsync is synchronous to clk.
module hsp_pixdiv #(
    parameter int CLK_PER_PIX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    output logic tick
);
    localparam int PW = hsp_pkg::cnt_w(CLK_PER_PIX);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_PIX - 1);

    logic [PW-1:0] phase_q;

    // Phase counter: cleared by reset or sync, wraps at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Tick on the last phase, never while sync holds the divider.
    always_comb tick = (phase_q == LAST) && !hsync;
endmodule

// File: rtl/hsp_loadseq.sv
// Module: byte load sequencer.
// Counts pixel ticks modulo PIX_PER_BYTE. The tick that finds slot zero is
// the load tick, so the first tick after sync loads the first byte. Every
// PIX_PER_BYTE-th tick after that loads again. Also registers a one-cycle
// request pulse after each load.
// Assumes tick is never high while hsync is high.
module hsp_loadseq #(
    parameter int PIX_PER_BYTE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic tick,
    output logic load,
    output logic req
);
    localparam int SW = hsp_pkg::cnt_w(PIX_PER_BYTE);
    localparam logic [SW-1:0] LAST = SW'(PIX_PER_BYTE - 1);

    logic [SW-1:0] slot_q;

    // Slot counter: held at zero by sync, advances one step per pixel tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync) begin
            slot_q <= '0;
        end else if (tick) begin
            slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

    // Load decision: a tick on slot zero.
    always_comb load = tick && (slot_q == '0);

    // Request pulse: follows each load by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= load;
        end
    end
endmodule

// File: rtl/hsp_shifter.sv
// Module: parallel-load pixel shift register.
// On a load it takes the input byte, or zero when gated off. On other
// ticks it shifts toward the MSB, so the MSB is always the pixel on show.
// It is held cleared while sync is high, so nothing reaches the output.
// Assumes load is only ever high together with tick.
module hsp_shifter #(
    parameter int PIX_PER_BYTE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hsync,
    input  logic                    tick,
    input  logic                    load,
    input  logic                    en,
    input  logic [PIX_PER_BYTE-1:0] din,
    output logic                    pix
);
    logic [PIX_PER_BYTE-1:0] sreg_q;
    logic [PIX_PER_BYTE-1:0] fill;

    // Byte to load: the input when enabled, otherwise blank.
    always_comb fill = en ? din : '0;

    // Shift register: clear, load or shift MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= fill;
        end else if (tick) begin
            sreg_q <= {sreg_q[PIX_PER_BYTE-2:0], 1'b0};
        end
    end

    // Pixel on show: the current MSB.
    always_comb pix = sreg_q[PIX_PER_BYTE-1];
endmodule

// File: rtl/hsync_pixel_serializer.sv
// Module: sync-locked overlay pixel serializer (top).
// Chains the divider, the load sequencer and the shift register. Sync
// restarts all three together, so each line's pixel grid starts at a fixed
// offset from the sync trailing edge.
// Assumes hsync, en and pix_byte are synchronous to clk.
module hsync_pixel_serializer #(
    parameter int PIX_PER_BYTE = hsp_pkg::PIX_PER_BYTE_DEF,
    parameter int CLK_PER_PIX  = hsp_pkg::CLK_PER_PIX_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hsync,
    input  logic                    en,
    input  logic [PIX_PER_BYTE-1:0] pix_byte,
    output logic                    byte_req,
    output logic                    overlay
);
    logic tick;
    logic load;

    hsp_pixdiv #(.CLK_PER_PIX(CLK_PER_PIX)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .hsync(hsync),
        .tick (tick)
    );

    hsp_loadseq #(.PIX_PER_BYTE(PIX_PER_BYTE)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .hsync(hsync),
        .tick (tick),
        .load (load),
        .req  (byte_req)
    );

    hsp_shifter #(.PIX_PER_BYTE(PIX_PER_BYTE)) u_shf (
        .clk  (clk),
        .rst_n(rst_n),
        .hsync(hsync),
        .tick (tick),
        .load (load),
        .en   (en),
        .din  (pix_byte),
        .pix  (overlay)
    );
endmodule

// File: rtl/hsync_pixel_serializer_chk.sv
// Checker: port-level timing properties of the serializer, attached to
// every instance of the top module by the bind below. It keeps its own
// count of the pixel phase since the sync trailing edge.
module hsync_pixel_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic byte_req,
    input logic overlay
);
    logic half_q;

    // Own pixel half-phase: zero during sync, toggles afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    // R2
    sync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (!overlay && !byte_req));

    // R3
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && $past(hsync)) ##1 !hsync |=> byte_req);

    // R4
    pixel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && !half_q && $past(!hsync)) |=> $stable(overlay));

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |=> !byte_req);
endmodule

bind hsync_pixel_serializer hsync_pixel_serializer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync   (hsync),
    .byte_req(byte_req),
    .overlay (overlay)
);

// File: tb/hsync_pixel_serializer_bench.sv
module hsync_pixel_serializer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       en = 1'b1;
    logic [7:0] pix_byte = 8'h00;
    logic       byte_req;
    logic       overlay;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hsync_pixel_serializer u_hsync_pixel_serializer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync   (hsync),
        .en      (en),
        .pix_byte(pix_byte),
        .byte_req(byte_req),
        .overlay (overlay)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Reset holds both outputs low (R1).
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 overlay in reset", overlay, 1'b0);
        check("R1 byte_req in reset", byte_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 overlay after release", overlay, 1'b0);
        check("R1 byte_req after release", byte_req, 1'b0);
    endtask

    // One line: sync of width sw, then nb bytes. Up to last_n edges after E0
    // are checked. Between loads the inverse byte is driven first (R7).
    task automatic t_line(input logic [7:0] d[4], input logic [3:0] ena,
                          input int sw, input int nb, input int last_n);
        @(negedge clk);
        hsync = 1'b1;
        for (int c = 0; c < sw; c++) begin
            @(negedge clk);
            check("R2 overlay in sync", overlay, 1'b0);
            check("R2 byte_req in sync", byte_req, 1'b0);
        end
        pix_byte = d[0];
        en = ena[0];
        hsync = 1'b0;
        for (int n = 0; n <= last_n; n++) begin
            @(negedge clk);
            if (n == 0) begin
                check("R3 no pixel at E0", overlay, 1'b0);
                check("R3 no req at E0", byte_req, 1'b0);
            end else begin
                int k = n - 1;
                int j = k / 16;
                int b = (k / 2) % 8;
                logic e_pix = (j < nb && ena[j]) ? d[j][7 - b] : 1'b0;
                logic e_req = (k % 16 == 0);
                if (n == 1) check("R3 first MSB", overlay, e_pix);
                else if (j < nb && !ena[j]) check("R8 blanked byte", overlay, e_pix);
                else if (k % 16 < 2) check("R5 byte boundary", overlay, e_pix);
                else check("R4/R7 pixel", overlay, e_pix);
                check(e_req ? "R6 req pulse" : "R6 no req", byte_req, e_req);
                if (e_req && j + 1 < nb) begin
                    pix_byte = ~d[j + 1];
                    en = ~ena[j + 1];
                end else if (e_req) begin
                    pix_byte = 8'h00;
                    en = 1'b1;
                end
                if (k % 16 == 8 && j + 1 < nb) begin
                    pix_byte = d[j + 1];
                    en = ena[j + 1];
                end
            end
        end
    endtask

    initial begin
        t_reset();
        // Alternating patterns, even sync width (R4, R5).
        t_line('{8'hA5, 8'h3C, 8'h81, 8'hFF}, 4'b1111, 4, 4, 64);
        // Line cut mid-byte on an odd edge, then odd-width sync (R9).
        t_line('{8'hF0, 8'h55, 8'h00, 8'h00}, 4'b0011, 3, 2, 21);
        t_line('{8'h96, 8'hC3, 8'h7E, 8'h01}, 4'b1111, 1, 4, 64);
        // Enable gating on alternate bytes (R8), short sync (R9).
        t_line('{8'hFF, 8'hFF, 8'hAA, 8'hFF}, 4'b0101, 2, 4, 64);
        // Trailing zero loads after last byte (R5).
        t_line('{8'h80, 8'h01, 8'h00, 8'h00}, 4'b0011, 5, 2, 48);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule